// File: doc/BRIEF.md
# Serial Receive Word Queue with Level Interrupt

This block sits between the word deserializer of a serial receive port and the CPU register interface. Every completed word arrives as a one-cycle strobe with its data and is stored in a first-in first-out queue. The CPU takes words out one at a time with a read request. The result comes back one cycle later on a data bus with a valid strobe. The queue's fill level is shown in a control/status word, next to the programmed interrupt threshold. A sticky interrupt flag is raised once the level reaches that threshold.

The deserializer and the CPU both use the queue, and they can act in the same cycle. When they do, the incoming word always wins. The read is not stalled and is never answered with bad data. It is held over and served in the first cycle that has no incoming word. The block also synchronises the receive frame-sync pin and corrects it for polarity. Software can then see whether a word transfer is in progress and time its reads to fall between transfers.

Full-queue pushes and empty-queue reads are reported through sticky error flags, which are cleared by writing 1.

Top module: `srx_fifo`

## Requirements
- R1: A `word_vld` strobe while the queue holds fewer than 16 words stores `word_in` and raises the level by one. The level is shown in `fifo_csr[12:8]`, and all other bits of `fifo_csr` except `[4:0]` read 0.
- R2: A read request in a cycle with no `word_vld` removes the oldest word. The word appears on `rd_data` with `rd_vld` high in the following cycle. `rd_vld` is a one-cycle pulse per served read.
- R3: When `word_vld` and a read request fall in the same cycle, the word is stored and the read is deferred. The read is served in the first later cycle without `word_vld`, and it returns the correct oldest word.
- R4: A read request that arrives while a deferred read is still pending merges with it. Exactly one `rd_vld` pulse results.
- R5: A `word_vld` strobe while 16 words are held is dropped, and it sets the sticky overflow flag `flag_csr[0]`. A pulse on `ovf_clr` clears that flag. If a new drop occurs in the same cycle, the set wins.
- R6: A served read with the queue empty returns `rd_data` = 0 with `rd_vld` high, and it sets the sticky underflow flag `flag_csr[1]`. A pulse on `unf_clr` clears that flag.
- R7: `fifo_csr[4:0]` echoes `thresh`. The interrupt flag (`irq` and `flag_csr[2]`) sets in the cycle after the level is at or above `thresh`. It stays set until acknowledged.
- R8: An `int_ack` pulse clears the interrupt flag in the next cycle. If the level is still at or above `thresh`, the flag sets again one cycle later.
- R9: `flag_csr[3]` shows the frame-sync phase. It is high when the pin is at its active level, where `fs_pol` = 0 means active high and 1 means active low. A pin change appears after two clock edges. A polarity change takes effect at once.
- R10: After reset the level is 0, `rd_vld` is 0, and every flag in `flag_csr` is 0 while `fs_pin` is held at 0 with `fs_pol` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_vld | input | 1 | Deserializer word-complete strobe |
| word_in | input | 16 | Received word |
| rd_req | input | 1 | CPU read request (one pop) |
| rd_data | output | 16 | Word returned for a served read |
| rd_vld | output | 1 | Read result valid pulse |
| thresh | input | 5 | Interrupt fill-level threshold |
| fs_pol | input | 1 | Frame-sync polarity, 1 = active low |
| fs_pin | input | 1 | Raw frame-sync pin |
| int_ack | input | 1 | Interrupt flag clear pulse |
| ovf_clr | input | 1 | Overflow flag write-1 clear |
| unf_clr | input | 1 | Underflow flag write-1 clear |
| fifo_csr | output | 16 | Level in [12:8], threshold in [4:0] |
| flag_csr | output | 16 | [0] overflow, [1] underflow, [2] interrupt, [3] frame-sync active |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted pointer or count shows up in the level field in the same cycle, and in the order of `rd_data` on the next served read. A defect in the collision logic shows up as a `rd_vld` pulse in a cycle where `word_vld` was high one cycle earlier. It can also show as a missing or doubled pulse one cycle after the collision ends. A fault in the interrupt or error flags shows on `irq` or `flag_csr` within one cycle of the level change, acknowledge or clear that should have moved them.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int LVL_W   = 5;
  localparam int FLG_OVF = 0;
  localparam int FLG_UNF = 1;
  localparam int FLG_IRQ = 2;
  localparam int FLG_FS  = 3;

  // Fill level has reached the programmed threshold.
  function automatic logic at_thresh(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] thr);
    return lvl >= thr;
  endfunction

  // Sticky flag update: a set event beats a clear.
  function automatic logic sticky(input logic cur, input logic set_ev,
                                  input logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/srx_store.sv
module srx_store
  import srx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_do,
  input  logic             pop_do,
  input  logic [DW-1:0]    wr_word,
  output logic [DW-1:0]    head_word,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST  = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] CAP   = LVL_W'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : AW'(p + 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_do) mem[wp] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_do) wp <= bump(wp);
      if (pop_do)  rp <= bump(rp);
      case ({push_do, pop_do})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head_word = mem[rp];
  assign level     = cnt;
  assign full      = (cnt == CAP);
  assign empty     = (cnt == '0);
endmodule

// File: rtl/srx_arb.sv
module srx_arb #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_vld,
  input  logic          rd_req,
  input  logic          full,
  input  logic          empty,
  input  logic [DW-1:0] head_word,
  output logic          push_do,
  output logic          pop_do,
  output logic          drop_evt,
  output logic          under_evt,
  output logic          defer_evt,
  output logic          rd_vld,
  output logic [DW-1:0] rd_data
);
  logic pend;
  logic demand;
  logic pop_req;

  // The incoming word always owns the cycle; a read waits for a free one.
  assign demand    = rd_req | pend;
  assign push_do   = word_vld & ~full;
  assign drop_evt  = word_vld & full;
  assign defer_evt = demand & word_vld;
  assign pop_req   = demand & ~word_vld;
  assign pop_do    = pop_req & ~empty;
  assign under_evt = pop_req & empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      pend   <= defer_evt;
      rd_vld <= pop_req;
      if (pop_do)         rd_data <= head_word;
      else if (under_evt) rd_data <= '0;
    end
  end
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_evt,
  input  logic             under_evt,
  input  logic             ovf_clr,
  input  logic             unf_clr,
  input  logic             int_ack,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  output logic             ovf_flag,
  output logic             unf_flag,
  output logic             irq_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      ovf_flag <= sticky(ovf_flag, drop_evt, ovf_clr);
      unf_flag <= sticky(unf_flag, under_evt, unf_clr);
      if (int_ack)                     irq_flag <= 1'b0;
      else if (at_thresh(level, thresh)) irq_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/srx_fsync.sv
module srx_fsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_pin,
  input  logic fs_pol,
  output logic fs_active
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= fs_pin;
        else             chain[i] <= chain[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign fs_active = chain[STAGES-1] ^ fs_pol;
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DW        = 16,
  parameter int DEPTH     = 16,
  parameter int FS_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_vld,
  input  logic [DW-1:0] word_in,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  input  logic [4:0]    thresh,
  input  logic          fs_pol,
  input  logic          fs_pin,
  input  logic          int_ack,
  input  logic          ovf_clr,
  input  logic          unf_clr,
  output logic [15:0]   fifo_csr,
  output logic [15:0]   flag_csr,
  output logic          irq
);
  logic [DW-1:0]    head_word;
  logic [LVL_W-1:0] level;
  logic             full, empty;
  logic             push_do, pop_do, drop_evt, under_evt, defer_evt;
  logic             ovf_flag, unf_flag, irq_flag, fs_active;

  srx_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_do(push_do), .pop_do(pop_do),
    .wr_word(word_in), .head_word(head_word), .level(level),
    .full(full), .empty(empty)
  );

  srx_arb #(.DW(DW)) u_arb (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .rd_req(rd_req),
    .full(full), .empty(empty), .head_word(head_word),
    .push_do(push_do), .pop_do(pop_do), .drop_evt(drop_evt),
    .under_evt(under_evt), .defer_evt(defer_evt),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  srx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt), .under_evt(under_evt),
    .ovf_clr(ovf_clr), .unf_clr(unf_clr), .int_ack(int_ack),
    .level(level), .thresh(thresh),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .irq_flag(irq_flag)
  );

  srx_fsync #(.STAGES(FS_STAGES)) u_fsync (
    .clk(clk), .rst_n(rst_n), .fs_pin(fs_pin), .fs_pol(fs_pol),
    .fs_active(fs_active)
  );

  always_comb begin
    fifo_csr         = '0;
    fifo_csr[12:8]   = level;
    fifo_csr[4:0]    = thresh;
    flag_csr          = '0;
    flag_csr[FLG_OVF] = ovf_flag;
    flag_csr[FLG_UNF] = unf_flag;
    flag_csr[FLG_IRQ] = irq_flag;
    flag_csr[FLG_FS]  = fs_active;
  end

  assign irq = irq_flag;
endmodule

// File: rtl/srx_fifo_chk.sv
module srx_fifo_chk
  import srx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_vld,
  input logic             rd_vld,
  input logic [DW-1:0]    rd_data,
  input logic [LVL_W-1:0] level,
  input logic [4:0]       thresh,
  input logic             push_do,
  input logic             pop_do,
  input logic             under_evt,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             irq_flag,
  input logic             int_ack
);
  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    push_do |=> level == LVL_W'($past(level) + 1'b1));

  p_write_blocks_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !rd_vld);

  p_no_dual_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_do && pop_do));

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    under_evt |=> (rd_vld && rd_data == '0));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !int_ack) |=> irq_flag);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(level >= thresh));

  p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !irq_flag);
endmodule

bind srx_fifo srx_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .rd_vld(rd_vld),
  .rd_data(rd_data), .level(level), .thresh(thresh), .push_do(push_do),
  .pop_do(pop_do), .under_evt(under_evt), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .irq_flag(irq_flag), .int_ack(int_ack)
);

// File: tb/srx_fifo_test.sv
module srx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic        rd_req = 1'b0;
  logic [15:0] rd_data;
  logic        rd_vld;
  logic [4:0]  thresh = 5'd31;
  logic        fs_pol = 1'b0;
  logic        fs_pin = 1'b0;
  logic        int_ack = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        unf_clr = 1'b0;
  logic [15:0] fifo_csr, flag_csr;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  srx_fifo uut (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld), .thresh(thresh),
    .fs_pol(fs_pol), .fs_pin(fs_pin), .int_ack(int_ack), .ovf_clr(ovf_clr),
    .unf_clr(unf_clr), .fifo_csr(fifo_csr), .flag_csr(flag_csr), .irq(irq)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<50000", cyc);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Row: req(4) wv(1) wd(16) rq(1) ev(1) ed(16) el(5) = 44 bits
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {4'd1, 1'b1, 16'hA001, 1'b0, 1'b0, 16'h0000, 5'd1},
    {4'd1, 1'b1, 16'hA002, 1'b0, 1'b0, 16'h0000, 5'd2},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hA001, 5'd1},
    {4'd3, 1'b1, 16'hA003, 1'b1, 1'b0, 16'h0000, 5'd2},
    {4'd3, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hA002, 5'd1},
    {4'd3, 1'b1, 16'hA004, 1'b1, 1'b0, 16'h0000, 5'd2},
    {4'd4, 1'b1, 16'hA005, 1'b1, 1'b0, 16'h0000, 5'd3},
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hA003, 5'd2},
    {4'd4, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 5'd2},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hA004, 5'd1},
    {4'd2, 1'b0, 16'h0000, 1'b1, 1'b1, 16'hA005, 5'd0},
    {4'd6, 1'b0, 16'h0000, 1'b1, 1'b1, 16'h0000, 5'd0}
  };

  initial begin
    // R10: reset state
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R10 level", 32'(fifo_csr), 32'h001F);
    chk("R10 rd_vld", 32'(rd_vld), 0);
    chk("R10 flags", 32'(flag_csr), 0);
    chk("R10 irq", 32'(irq), 0);

    // Vector walk: R1 push, R2 read, R3 collision, R4 merge, R6 empty read
    for (int i = 0; i < NV; i++) begin
      word_vld = VEC[i][39];
      word_in  = VEC[i][38:23];
      rd_req   = VEC[i][22];
      tick();
      chk($sformatf("R%0d row%0d rd_vld", VEC[i][43:40], i),
          32'(rd_vld), 32'(VEC[i][21]));
      if (VEC[i][21])
        chk($sformatf("R%0d row%0d rd_data", VEC[i][43:40], i),
            32'(rd_data), 32'(VEC[i][20:5]));
      chk($sformatf("R%0d row%0d level", VEC[i][43:40], i),
          32'(fifo_csr[12:8]), 32'(VEC[i][4:0]));
    end
    word_vld = 1'b0; rd_req = 1'b0;

    // R6: underflow flag sticky then cleared
    tick();
    chk("R6 unf set", 32'(flag_csr[1]), 1);
    unf_clr = 1'b1; tick(); unf_clr = 1'b0;
    chk("R6 unf clr", 32'(flag_csr[1]), 0);

    // R5: overflow, dropped word, order kept
    for (int i = 0; i < 17; i++) begin
      word_vld = 1'b1; word_in = 16'h0B00 + 16'(i); tick();
    end
    word_vld = 1'b0;
    chk("R5 level full", 32'(fifo_csr[12:8]), 16);
    chk("R5 ovf set", 32'(flag_csr[0]), 1);
    for (int i = 0; i < 16; i++) begin
      rd_req = 1'b1; tick();
      if (i == 0)  chk("R5 first word", 32'(rd_data), 32'h0B00);
      if (i == 15) chk("R5 last kept word", 32'(rd_data), 32'h0B0F);
    end
    rd_req = 1'b0;
    chk("R5 drained", 32'(fifo_csr[12:8]), 0);
    chk("R5 ovf sticky", 32'(flag_csr[0]), 1);
    ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    chk("R5 ovf clr", 32'(flag_csr[0]), 0);

    // R7 / R8: threshold interrupt
    thresh = 5'd3;
    for (int i = 0; i < 2; i++) begin
      word_vld = 1'b1; word_in = 16'hC000 + 16'(i); tick();
    end
    chk("R7 below thr", 32'(irq), 0);
    word_in = 16'hC002; tick(); word_vld = 1'b0;
    chk("R7 same cycle as level", 32'(irq), 0);
    tick();
    chk("R7 irq set", 32'(irq), 1);
    chk("R7 flag bit", 32'(flag_csr[2]), 1);
    chk("R7 csr", 32'(fifo_csr), 32'h0303);
    int_ack = 1'b1; tick(); int_ack = 1'b0;
    chk("R8 ack clears", 32'(irq), 0);
    tick();
    chk("R8 reassert", 32'(irq), 1);
    rd_req = 1'b1; tick(); rd_req = 1'b0;
    chk("R7 sticky below thr", 32'(irq), 1);
    int_ack = 1'b1; tick(); int_ack = 1'b0;
    chk("R8 ack low level", 32'(irq), 0);
    tick();
    chk("R8 stays clear", 32'(irq), 0);

    // R9: frame-sync phase
    fs_pin = 1'b1; tick();
    chk("R9 one edge", 32'(flag_csr[3]), 0);
    tick();
    chk("R9 active high", 32'(flag_csr[3]), 1);
    fs_pol = 1'b1; #1;
    chk("R9 polarity flip", 32'(flag_csr[3]), 0);
    fs_pin = 1'b0; tick(); tick();
    chk("R9 active low", 32'(flag_csr[3]), 1);

    report();
  end
endmodule